// File: doc/BRIEF.md
# Descriptor-Driven Item Transfer Engine

This block moves data between a keyed configuration item store and system memory without the host touching the item data port byte by byte. The host writes the memory address of a 16-byte descriptor into a 64-bit pointer register. Writing the low half of that register starts the engine. The engine fetches the descriptor from memory and decodes its control word. Depending on the control bits, it can re-select an item, copy item bytes out to memory, copy memory bytes into a writable item, or advance the item offset without moving data. At the end it writes a status word back over the descriptor's control field.

The item side is a cursor made of a key and a byte offset. The host selector write and the engine share this cursor. The item store answers combinationally with the selected item's length, its writability and the byte at the current offset. Memory is reached through a byte-wide master port. The port carries one request at a time, and every request receives exactly one response pulse.

Top module: `desc_xfer_engine`

## Requirements
- R1: While the engine is idle, a read of the pointer register returns 0x51454d5520434647. While it is busy, the read returns the loaded pointer. The stored pointer is zero after reset and is cleared to zero when each operation ends, so a later write of the low half alone starts from upper half zero.
- R2: A write of the low half (bit field 31:0, byte offset 4) starts an operation, whether or not the upper half is written in the same cycle. A write of the upper half alone (bits 63:32) starts nothing. Pointer writes made while busy are ignored.
- R3: The descriptor is fetched as 16 bytes from pointer+0 upward. It is big-endian: bytes 0..3 hold the control word, 4..7 the length, 8..15 the data address.
- R4: Control bit 3 (select) loads the key from control bits 31:16 and zeroes the offset. This happens before any other action of the same descriptor.
- R5: Control bit 1 (read) copies length bytes from the item at the current offset to memory starting at the data address. Bytes at offsets at or beyond the item length are written as 0x00. The offset advances by length.
- R6: Control bit 4 (write), with bit 1 clear, copies length bytes from memory at the data address into the item at the current offset. The offset advances by length.
- R7: A write to a read-only item, or one whose offset plus length exceeds the item length, moves no byte into the item and leaves the offset unchanged. It also reports an error.
- R8: Control bit 2 (skip), with bits 1 and 4 clear, advances the offset by length. Apart from the descriptor fetch and the status write, it makes no memory access.
- R9: Read takes precedence over write, and write over skip, when several of these bits are set.
- R10: On completion the four control bytes at pointer+0..3 are rewritten as 00 00 00 00 on success, or 00 00 00 01 on error.
- R11: A host selector write loads the key and zeroes the offset. It is ignored while the engine is busy. When it comes in the same cycle as the starting pointer write, it is applied before the descriptor runs.
- R12: A memory request lasts one cycle and never overlaps an outstanding one. No memory request and no item write occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ptr_wr_hi_i | input | 1 | Write strobe for pointer bits 63:32 |
| ptr_wr_lo_i | input | 1 | Write strobe for pointer bits 31:0 (starts operation) |
| ptr_wdata_i | input | 64 | Pointer write data |
| ptr_rdata_o | output | 64 | Pointer read value (signature when idle) |
| busy_o | output | 1 | Operation in progress |
| sel_wr_i | input | 1 | Host selector write strobe |
| sel_key_i | input | 16 | Host selector key |
| item_key_o | output | 16 | Current item key |
| item_off_o | output | 32 | Current item byte offset |
| item_len_i | input | 32 | Length of the selected item |
| item_writable_i | input | 1 | Selected item accepts writes |
| item_rdata_i | input | 8 | Item byte at current offset |
| item_we_o | output | 1 | Item byte write strobe at current offset |
| item_wdata_o | output | 8 | Item byte write data |
| mem_req_o | output | 1 | Memory request pulse |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rvalid_i | input | 1 | Response pulse (read data or write acknowledge) |
| mem_rdata_i | input | 8 | Read data |

## Verification
Two sources can move the item cursor in the same cycle: a host selector write and the starting pointer write. The bench raises both strobes on the same edge, with a descriptor that carries no select bit. It then checks that the bytes copied to memory come from the host-chosen key at offset zero. A second case raises a selector write in the middle of a running operation and judges at the cursor ports that the key stays where the descriptor left it. Control words with several operation bits set are also swept, to show that read beats write and write beats skip.

// File: rtl/dx_pkg.sv
package dx_pkg;
  localparam int AW = 64;
  localparam int LW = 32;
  localparam int KW = 16;
  localparam int BW = 8;
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
  localparam logic [AW-1:0] SIG = 64'h51454d5520434647;
  localparam int C_ERR  = 0;
  localparam int C_RD   = 1;
  localparam int C_SKIP = 2;
  localparam int C_SEL  = 3;
  localparam int C_WR   = 4;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SEL, ST_CHECK, ST_MOVE, ST_STATUS, ST_DONE
  } state_e;
endpackage

// File: rtl/dx_ptr_reg.sv
module dx_ptr_reg
  import dx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          done_i,
  output logic          start_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] rdata_o
);
  localparam int HW = AW / 2;
  logic [AW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (done_i) q <= '0;
    else if (!busy_i) begin
      if (wr_hi_i) q[AW-1:HW] <= wdata_i[AW-1:HW];
      if (wr_lo_i) q[HW-1:0]  <= wdata_i[HW-1:0];
    end
  end

  assign start_o = wr_lo_i && !busy_i;
  assign base_o  = q;
  assign rdata_o = busy_i ? q : SIG;
endmodule

// File: rtl/dx_cursor.sv
module dx_cursor
  import dx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_sel_i,
  input  logic [KW-1:0] host_key_i,
  input  logic          busy_i,
  input  logic          eng_sel_i,
  input  logic [KW-1:0] eng_key_i,
  input  logic          adv_i,
  input  logic [LW-1:0] adv_by_i,
  output logic [KW-1:0] key_o,
  output logic [LW-1:0] off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o <= '0;
      off_o <= '0;
    end else if (eng_sel_i) begin
      key_o <= eng_key_i;
      off_o <= '0;
    end else if (host_sel_i && !busy_i) begin
      key_o <= host_key_i;
      off_o <= '0;
    end else if (adv_i) begin
      off_o <= off_o + adv_by_i;
    end
  end
endmodule

// File: rtl/dx_engine_fsm.sv
module dx_engine_fsm
  import dx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] item_len_i,
  input  logic          item_writable_i,
  input  logic [BW-1:0] item_rdata_i,
  input  logic [LW-1:0] item_off_i,
  input  logic          mem_rvalid_i,
  input  logic [BW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          sel_o,
  output logic [KW-1:0] sel_key_o,
  output logic          adv_o,
  output logic [LW-1:0] adv_by_o,
  output logic          item_we_o,
  output logic [BW-1:0] item_wdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [BW-1:0] mem_wdata_o
);
  localparam int DBITS = DESC_BYTES * BW;

  state_e         state;
  logic [LW-1:0]  cnt;
  logic           pend;
  logic           err;
  logic [DBITS-1:0] desc;

  logic [31:0]   ctrl;
  logic [LW-1:0] len;
  logic [AW-1:0] daddr;
  logic          is_rd, is_wr, is_sk, wr_bad, rsp, last_mv;

  assign ctrl  = desc[DBITS-1 -: 32];
  assign len   = desc[DBITS-33 -: LW];
  assign daddr = desc[AW-1:0];
  assign is_rd = ctrl[C_RD];
  assign is_wr = ctrl[C_WR] && !ctrl[C_RD];
  assign is_sk = ctrl[C_SKIP] && !ctrl[C_RD] && !ctrl[C_WR];
  // one sum covers both a start and an end beyond the item
  assign wr_bad = !item_writable_i ||
                  (({1'b0, item_off_i} + {1'b0, len}) > {1'b0, item_len_i});
  assign rsp     = pend && mem_rvalid_i;
  assign last_mv = (cnt == len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
      err   <= 1'b0;
      desc  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          state <= ST_FETCH;
          cnt   <= '0;
          pend  <= 1'b0;
          err   <= 1'b0;
        end
        ST_FETCH: begin
          if (!pend) pend <= 1'b1;
          else if (mem_rvalid_i) begin
            pend <= 1'b0;
            desc <= {desc[DBITS-BW-1:0], mem_rdata_i};
            if (cnt == LW'(DESC_BYTES - 1)) begin
              cnt   <= '0;
              state <= ST_SEL;
            end else cnt <= cnt + 1'b1;
          end
        end
        ST_SEL: state <= ST_CHECK;
        ST_CHECK: begin
          cnt <= '0;
          if (is_rd) state <= (len == '0) ? ST_STATUS : ST_MOVE;
          else if (is_wr) begin
            if (wr_bad) begin
              err   <= 1'b1;
              state <= ST_STATUS;
            end else state <= (len == '0) ? ST_STATUS : ST_MOVE;
          end else state <= ST_STATUS;
        end
        ST_MOVE: begin
          if (!pend) pend <= 1'b1;
          else if (mem_rvalid_i) begin
            pend <= 1'b0;
            if (last_mv) begin
              cnt   <= '0;
              state <= ST_STATUS;
            end else cnt <= cnt + 1'b1;
          end
        end
        ST_STATUS: begin
          if (!pend) pend <= 1'b1;
          else if (mem_rvalid_i) begin
            pend <= 1'b0;
            if (cnt == LW'(STAT_BYTES - 1)) begin
              cnt   <= '0;
              state <= ST_DONE;
            end else cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_DONE);
  assign sel_o     = (state == ST_SEL) && ctrl[C_SEL];
  assign sel_key_o = ctrl[31:16];

  assign adv_o    = ((state == ST_MOVE) && rsp) || ((state == ST_CHECK) && is_sk);
  assign adv_by_o = (state == ST_CHECK) ? len : LW'(1);

  assign item_we_o    = (state == ST_MOVE) && is_wr && rsp;
  assign item_wdata_o = mem_rdata_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_i + AW'(cnt);
    mem_wdata_o = '0;
    case (state)
      ST_FETCH: mem_req_o = !pend;
      ST_MOVE: begin
        mem_req_o   = !pend;
        mem_we_o    = is_rd;
        mem_addr_o  = daddr + AW'(cnt);
        mem_wdata_o = (item_off_i < item_len_i) ? item_rdata_i : '0;
      end
      ST_STATUS: begin
        mem_req_o   = !pend;
        mem_we_o    = 1'b1;
        mem_wdata_o = (cnt == LW'(STAT_BYTES - 1)) ? {{(BW-1){1'b0}}, err} : '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/desc_xfer_engine.sv
module desc_xfer_engine
  import dx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_wr_hi_i,
  input  logic          ptr_wr_lo_i,
  input  logic [AW-1:0] ptr_wdata_i,
  output logic [AW-1:0] ptr_rdata_o,
  output logic          busy_o,
  input  logic          sel_wr_i,
  input  logic [KW-1:0] sel_key_i,
  output logic [KW-1:0] item_key_o,
  output logic [LW-1:0] item_off_o,
  input  logic [LW-1:0] item_len_i,
  input  logic          item_writable_i,
  input  logic [BW-1:0] item_rdata_i,
  output logic          item_we_o,
  output logic [BW-1:0] item_wdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [BW-1:0] mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [BW-1:0] mem_rdata_i
);
  logic          start, done, eng_sel, adv;
  logic [AW-1:0] base;
  logic [KW-1:0] eng_key;
  logic [LW-1:0] adv_by;

  dx_ptr_reg u_ptr (
    .clk_i, .rst_ni,
    .wr_hi_i (ptr_wr_hi_i),
    .wr_lo_i (ptr_wr_lo_i),
    .wdata_i (ptr_wdata_i),
    .busy_i  (busy_o),
    .done_i  (done),
    .start_o (start),
    .base_o  (base),
    .rdata_o (ptr_rdata_o)
  );

  dx_cursor u_cur (
    .clk_i, .rst_ni,
    .host_sel_i (sel_wr_i),
    .host_key_i (sel_key_i),
    .busy_i     (busy_o),
    .eng_sel_i  (eng_sel),
    .eng_key_i  (eng_key),
    .adv_i      (adv),
    .adv_by_i   (adv_by),
    .key_o      (item_key_o),
    .off_o      (item_off_o)
  );

  dx_engine_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i         (start),
    .base_i          (base),
    .item_len_i      (item_len_i),
    .item_writable_i (item_writable_i),
    .item_rdata_i    (item_rdata_i),
    .item_off_i      (item_off_o),
    .mem_rvalid_i    (mem_rvalid_i),
    .mem_rdata_i     (mem_rdata_i),
    .busy_o          (busy_o),
    .done_o          (done),
    .sel_o           (eng_sel),
    .sel_key_o       (eng_key),
    .adv_o           (adv),
    .adv_by_o        (adv_by),
    .item_we_o       (item_we_o),
    .item_wdata_o    (item_wdata_o),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o)
  );
endmodule

// File: rtl/dx_xfer_chk.sv
module dx_xfer_chk
  import dx_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ptr_wr_lo_i,
  input logic          busy_o,
  input logic          sel_wr_i,
  input logic [LW-1:0] item_off_o,
  input logic [LW-1:0] item_len_i,
  input logic          item_writable_i,
  input logic          item_we_o,
  input logic          mem_req_o
);
  // R2
  start_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_wr_lo_i && !busy_o) |=> busy_o);
  // R12
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !item_we_o));
  // R7
  write_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_we_o |-> item_writable_i);
  // R7
  write_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_we_o |-> (item_off_o < item_len_i));
  // R11
  host_sel_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && !busy_o) |=> (item_off_o == '0));
endmodule

bind desc_xfer_engine dx_xfer_chk u_chk (.*);

// File: tb/desc_xfer_engine_tb.sv
module desc_xfer_engine_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptr_wr_hi_i = 1'b0, ptr_wr_lo_i = 1'b0;
  logic [63:0] ptr_wdata_i = '0, ptr_rdata_o;
  logic        busy_o;
  logic        sel_wr_i = 1'b0;
  logic [15:0] sel_key_i = '0, item_key_o;
  logic [31:0] item_off_o, item_len_i;
  logic        item_writable_i;
  logic [7:0]  item_rdata_i, item_wdata_o;
  logic        item_we_o;
  logic        mem_req_o, mem_we_o;
  logic [63:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        mem_rvalid_i;

  localparam logic [63:0] SIG = 64'h51454d5520434647;
  localparam logic [31:0] C_RD = 32'h2, C_SKIP = 32'h4, C_SEL = 32'h8, C_WR = 32'h10;

  int checks = 0, errors = 0;
  logic [7:0]  mem [256];
  logic [7:0]  items [4][32];
  logic [1:0]  rv = '0;
  logic [7:0]  rd_q = '0, rd_q2 = '0;
  int          req_cnt = 0;
  logic [63:0] first_addr = '0;

  always #4 clk_i = ~clk_i;

  desc_xfer_engine u_dut (.*);

  function automatic int ilen(int k);
    case (k)
      0: return 3; 1: return 5; 2: return 6; default: return 8;
    endcase
  endfunction

  assign item_len_i      = 32'(ilen(int'(item_key_o[1:0])));
  assign item_writable_i = item_key_o[0];
  assign item_rdata_i    = items[item_key_o[1:0]][item_off_o[4:0]];
  assign mem_rvalid_i    = rv[1];
  assign mem_rdata_i     = rd_q2;

  always @(posedge clk_i) begin
    rv    <= {rv[0], mem_req_o};
    rd_q2 <= rd_q;
    if (mem_req_o) begin
      if (req_cnt == 0) first_addr = mem_addr_o;
      req_cnt = req_cnt + 1;
      if (mem_we_o) mem[mem_addr_o[7:0]] = mem_wdata_o;
      else rd_q <= mem[mem_addr_o[7:0]];
    end
    if (item_we_o) items[item_key_o[1:0]][item_off_o[4:0]] = item_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] ctrl, input logic [31:0] len, input logic [63:0] da);
    for (int i = 0; i < 4; i++) mem[i]     = ctrl[31-8*i -: 8];
    for (int i = 0; i < 4; i++) mem[4+i]   = len[31-8*i -: 8];
    for (int i = 0; i < 8; i++) mem[8+i]   = da[63-8*i -: 8];
  endtask

  task automatic trigger(input bit hsel, input logic [15:0] hkey);
    req_cnt = 0;
    @(negedge clk_i);
    ptr_wr_lo_i = 1'b1; ptr_wdata_i = 64'h0;
    sel_wr_i = hsel; sel_key_i = hkey;
    @(negedge clk_i);
    ptr_wr_lo_i = 1'b0; sel_wr_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic run_op(input logic [31:0] ctrl, input logic [31:0] len, input logic [63:0] da);
    put_desc(ctrl, len, da);
    trigger(1'b0, 16'h0);
    wait_idle();
  endtask

  function automatic logic [31:0] status_word();
    return {mem[0], mem[1], mem[2], mem[3]};
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] snap [32];
    logic [7:0] src  [8];
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 32; i++) items[k][i] = 8'(k*37 + i*5 + 1);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(ptr_rdata_o == SIG, "R1 idle signature", ptr_rdata_o, SIG);
    chk(!busy_o && !mem_req_o, "R12 idle after reset", busy_o, 0);
    chk(item_off_o == 0 && item_key_o == 0, "R11 cursor reset", item_off_o, 0);

    // R2 upper half alone starts nothing
    ptr_wr_hi_i = 1'b1; ptr_wdata_i = 64'h0000_0012_dead_beef;
    @(negedge clk_i);
    ptr_wr_hi_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R2 high half no start", busy_o, 0);

    // R1/R2/R3: low half starts with retained high half
    put_desc(C_SEL | 32'h0002_0000, 0, 0);
    trigger(1'b0, 16'h0);
    chk(busy_o, "R2 low half start", busy_o, 1);
    chk(ptr_rdata_o == 64'h0000_0012_0000_0000, "R1 busy shows pointer", ptr_rdata_o, 64'h12_0000_0000);
    wait_idle();
    chk(first_addr == 64'h0000_0012_0000_0000, "R3 fetch address", first_addr, 64'h12_0000_0000);
    chk(ptr_rdata_o == SIG, "R1 signature after op", ptr_rdata_o, SIG);
    chk(item_key_o == 2 && item_off_o == 0, "R4 select key", item_key_o, 2);
    run_op(32'h0, 0, 0);
    chk(first_addr == 64'h0, "R1 pointer cleared after op", first_addr, 0);
    chk(status_word() == 0, "R10 no-op status", status_word(), 0);

    // main sweep
    for (int k = 0; k < 4; k++) begin
      for (int o = 0; o <= ilen(k) + 1; o++) begin
        for (int ni = 0; ni < 4; ni++) begin
          for (int op = 0; op < 2; op++) begin
            int n;
            n = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 3 : 5;
            run_op({16'(k), 16'h0} | C_SEL | C_SKIP, 32'(o), 0);
            chk(item_key_o == 16'(k) && item_off_o == 32'(o), "R4 R8 select then skip",
                item_off_o, o);
            chk(req_cnt == 20, "R8 skip memory traffic", req_cnt, 20);
            chk(status_word() == 0, "R10 skip status", status_word(), 0);
            if (op == 0) begin
              for (int i = 0; i < 8; i++) mem[8'h40 + i] = 8'hEE;
              run_op(C_RD, 32'(n), 64'h40);
              for (int i = 0; i < 8; i++) begin
                logic [7:0] e;
                e = (i >= n) ? 8'hEE : (o + i < ilen(k)) ? items[k][o+i] : 8'h00;
                chk(mem[8'h40 + i] == e, "R5 read byte", mem[8'h40 + i], e);
              end
              chk(item_off_o == 32'(o + n), "R5 read offset", item_off_o, o + n);
              chk(req_cnt == 20 + n, "R12 read traffic", req_cnt, 20 + n);
              chk(status_word() == 0, "R10 read status", status_word(), 0);
            end else begin
              bit bad;
              for (int i = 0; i < 8; i++) begin
                src[i] = 8'(k*16 + o*3 + i + 8'h91);
                mem[8'h80 + i] = src[i];
              end
              for (int i = 0; i < 32; i++) snap[i] = items[k][i];
              bad = (k % 2 == 0) || (o + n > ilen(k));
              run_op(C_WR, 32'(n), 64'h80);
              for (int i = 0; i < 10; i++) begin
                logic [7:0] e;
                e = (!bad && i >= o && i < o + n) ? src[i-o] : snap[i];
                chk(items[k][i] == e, bad ? "R7 rejected write untouched" : "R6 write byte",
                    items[k][i], e);
              end
              chk(item_off_o == 32'(bad ? o : o + n), bad ? "R7 offset kept" : "R6 write offset",
                  item_off_o, bad ? o : o + n);
              chk(status_word() == (bad ? 32'h1 : 32'h0), "R10 R7 write status",
                  status_word(), bad ? 1 : 0);
              chk(req_cnt == (bad ? 20 : 20 + n), "R7 write traffic", req_cnt, bad ? 20 : 20 + n);
            end
          end
        end
      end
    end

    // R9 read beats write and skip
    for (int i = 0; i < 4; i++) snap[i] = items[1][i];
    run_op(32'h0001_0000 | C_SEL | C_RD | C_WR | C_SKIP, 2, 64'h40);
    chk(mem[8'h40] == items[1][0] && mem[8'h41] == items[1][1], "R9 read wins", mem[8'h41], items[1][1]);
    chk(items[1][0] == snap[0] && items[1][1] == snap[1], "R9 item untouched", items[1][0], snap[0]);
    chk(item_off_o == 2, "R9 read offset", item_off_o, 2);
    // R9 write beats skip (read-only item -> error, no advance)
    run_op(32'h0000_0000 | C_SEL | C_WR | C_SKIP, 2, 64'h80);
    chk(status_word() == 1 && item_off_o == 0, "R9 write over skip", item_off_o, 0);

    // R11 host select same cycle as start
    run_op(32'h0001_0000 | C_SEL | C_SKIP, 2, 0);
    put_desc(C_RD, 1, 64'h40);
    trigger(1'b1, 16'h3);
    wait_idle();
    chk(mem[8'h40] == items[3][0], "R11 same-cycle select", mem[8'h40], items[3][0]);
    chk(item_key_o == 3 && item_off_o == 1, "R11 cursor after", item_off_o, 1);
    // R11 host select while busy ignored
    put_desc(C_RD, 1, 64'h40);
    trigger(1'b0, 16'h0);
    sel_wr_i = 1'b1; sel_key_i = 16'h2;
    @(negedge clk_i);
    sel_wr_i = 1'b0;
    wait_idle();
    chk(item_key_o == 3 && item_off_o == 2, "R11 busy select ignored", item_key_o, 3);
    chk(mem[8'h40] == items[3][1], "R11 busy read data", mem[8'h40], items[3][1]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule